// File: doc/BRIEF.md
# Infrared Link Interrupt Controller

This block gathers single-cycle event pulses from an infrared serial link core and turns them into one level-sensitive interrupt request. The events are kept in two groups of sticky status flags: one group for the slow serial link mode and one shared by the medium and fast modes. The link mode in force at the moment of an event decides which group records it, and the same status bit position carries a different meaning in each group (bit 9 is a receive timeout in slow mode and an abort in medium/fast mode; bit 8 is a framing error in slow mode and a CRC error in medium/fast mode).

Software reads and writes the block through a plain 16-bit register port with a 3-bit address. Each group has a read-only status register, a mask register and a write-one-to-clear register. A mode register holds the 2-bit link mode together with three group-level mask bits, one for each group and one for an external FIFO receive request. The interrupt line is high while any unmasked, latched event is present in an enabled group, or while the FIFO request is high and not masked.

Top module: `ir_evt_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset every status register reads 0x0000, both group mask registers read 0x8B80, the mode register reads 0x0111 and irq_o is 0.
- R2: The mode field is bits 15:14 of the mode register (address 0). An event is recorded in the slow group (status at address 1) when the field is 00, in the medium/fast group (status at address 4) when it is 10 or 11, and in neither when it is 01.
- R3: Event input evt_i[4] sets status bit 15, evt_i[3] bit 11, evt_i[2] bit 9, evt_i[1] bit 8 and evt_i[0] bit 7, on the clock edge where the pulse is sampled; the bit then stays set until cleared.
- R4: Writing the clear register of a group (address 3 for slow, 6 for medium/fast) clears each status bit whose data bit is 1 and leaves bits written 0 unchanged; clear registers read 0x0000.
- R5: When an event pulse and a clear write for the same status bit meet on the same edge, the bit ends up set.
- R6: A 1 in bit 15, 11, 9, 8 or 7 of a group mask register (address 2 for slow, 5 for medium/fast) keeps the matching status bit from raising irq_o; the status bit still reads back as set.
- R7: Mode register bit 0 masks the whole slow group and bit 4 masks the whole medium/fast group from irq_o when 1.
- R8: Mode register bit 8, when 1, keeps the fifo_req_i input from raising irq_o.
- R9: irq_o is 1 exactly when some group has a status bit set whose mask bit is 0 while its group mask bit in the mode register is 0, or fifo_req_i is 1 with mode bit 8 at 0; it follows register changes in the cycle after the edge that made them.
- R10: Writes to the status registers have no effect, and unused bit positions of every register read as 0 (mode register keeps bits 15, 14, 8, 4, 0; mask and status registers keep 15, 11, 9, 8, 7).
- R11: reg_rdata_o returns the addressed register combinationally in the same cycle; address 7 reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe, acts on the rising edge |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i |
| evt_i | input | 5 | Event pulses: 4 rx end, 3 area overflow, 2 timeout/abort, 1 framing/CRC error, 0 tx end |
| fifo_req_i | input | 1 | Level request from the FIFO receive path |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong status or mask flip-flop shows at the ports in the cycle after the edge that corrupted it: either irq_o differs from the value implied by the register contents or the read port returns a different word when that register is addressed. A misrouted event appears as a bit in the wrong group's status, visible on the next read of either status address. Because every register is readable combinationally, a corruption can be found one clock after it happens, provided the bench reads the register or the state is unmasked.

// File: rtl/ir_irq_pkg.sv
// Package: shared constants, register addresses and the event-to-bit map
// for the infrared link interrupt controller.
package ir_irq_pkg;

    localparam int DW     = 16;   // register width
    localparam int NEV    = 5;    // event inputs per cycle
    localparam int NGRP   = 2;    // status groups
    localparam int AW     = 3;    // register address width

    // bit positions that exist in status and mask registers
    localparam logic [DW-1:0] EVT_BITS   = 16'h8B80;
    // writable bits of the mode register and its reset value
    localparam logic [DW-1:0] MODE_WMASK = 16'hC111;
    localparam logic [DW-1:0] MODE_RST   = 16'h0111;

    // positions inside the mode register
    localparam int MB_SLOW_OFF = 0;
    localparam int MB_FAST_OFF = 4;
    localparam int MB_FIFO_OFF = 8;

    typedef enum logic [1:0] {
        LM_SLOW = 2'b00,
        LM_RSVD = 2'b01,
        LM_FAST = 2'b10,
        LM_MED  = 2'b11
    } link_mode_e;

    // register map
    localparam logic [AW-1:0] A_MODE  = 3'd0;
    localparam logic [AW-1:0] A_S_STS = 3'd1;
    localparam logic [AW-1:0] A_S_MSK = 3'd2;
    localparam logic [AW-1:0] A_S_CLR = 3'd3;
    localparam logic [AW-1:0] A_F_STS = 3'd4;
    localparam logic [AW-1:0] A_F_MSK = 3'd5;
    localparam logic [AW-1:0] A_F_CLR = 3'd6;

    // place the five event pulses at their status bit positions
    function automatic logic [DW-1:0] evt_to_bits(input logic [NEV-1:0] e);
        logic [DW-1:0] b;
        b     = '0;
        b[15] = e[4];
        b[11] = e[3];
        b[9]  = e[2];
        b[8]  = e[1];
        b[7]  = e[0];
        return b;
    endfunction

endpackage

// File: rtl/ir_mode_reg.sv
// Module: mode register. Holds the 2-bit link mode and the three
// group-level mask bits. Assumes writes are single-cycle strobes.
module ir_mode_reg
    import ir_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] value_o,
    output link_mode_e    mode_o,
    output logic          slow_off_o,
    output logic          fast_off_o,
    output logic          fifo_off_o
);

    logic [DW-1:0] mode_q;

    // register update: reset to all-masked slow mode, keep only defined bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_RST;
        else if (we_i)
            mode_q <= wdata_i & MODE_WMASK;
    end

    // decode fields
    always_comb begin
        value_o    = mode_q;
        mode_o     = link_mode_e'(mode_q[15:14]);
        slow_off_o = mode_q[MB_SLOW_OFF];
        fast_off_o = mode_q[MB_FAST_OFF];
        fifo_off_o = mode_q[MB_FIFO_OFF];
    end

    // R10: undefined bits never appear
    p_mode_rsvd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q & ~MODE_WMASK) == '0);

    // R1: reset value
    p_mode_reset_r1: assert property (@(posedge clk)
        !rst_n |=> mode_q == MODE_RST);

endmodule

// File: rtl/ir_grp_bank.sv
// Module: one event group. Sticky status flags with write-one-to-clear,
// a per-bit mask and a pending flag. Assumes events arrive already routed
// to this group and placed at their bit positions.
module ir_grp_bank
    import ir_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] set_i,
    input  logic          clr_we_i,
    input  logic          msk_we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] status_o,
    output logic [DW-1:0] mask_o,
    output logic          pend_o
);

    logic [DW-1:0] sts_q;
    logic [DW-1:0] msk_q;
    logic [DW-1:0] clr_bits;

    // clear vector from the write strobe
    always_comb clr_bits = clr_we_i ? (wdata_i & EVT_BITS) : '0;

    // status: clear first, then set, so a same-edge event wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            sts_q <= '0;
        else
            sts_q <= ((sts_q & ~clr_bits) | set_i) & EVT_BITS;
    end

    // mask: reset to all masked
    always_ff @(posedge clk) begin
        if (!rst_n)
            msk_q <= EVT_BITS;
        else if (msk_we_i)
            msk_q <= wdata_i & EVT_BITS;
    end

    // outputs
    always_comb begin
        status_o = sts_q;
        mask_o   = msk_q;
        pend_o   = |(sts_q & ~msk_q);
    end

    // R3/R5: every event seen at an edge is present afterwards
    p_evt_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & EVT_BITS)) |=> ((sts_q & $past(set_i & EVT_BITS)) == $past(set_i & EVT_BITS)));

    // R4: a clear without events removes the requested bits
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && set_i == '0) |=> ((sts_q & $past(wdata_i)) == '0));

    // R3: with no event and no clear the status holds
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we_i && set_i == '0) |=> $stable(sts_q));

    // R1: reset state of this group
    p_bank_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (sts_q == '0 && msk_q == EVT_BITS));

endmodule

// File: rtl/ir_evt_irq_ctrl.sv
// Module: top of the infrared link interrupt controller. Routes events to
// the group chosen by the link mode, decodes the register port and forms
// the interrupt. Assumes evt_i pulses are synchronous to clk.
module ir_evt_irq_ctrl
    import ir_irq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we_i,
    input  logic [AW-1:0]  reg_addr_i,
    input  logic [DW-1:0]  reg_wdata_i,
    output logic [DW-1:0]  reg_rdata_o,
    input  logic [NEV-1:0] evt_i,
    input  logic           fifo_req_i,
    output logic           irq_o
);

    link_mode_e    mode;
    logic [DW-1:0] mode_val;
    logic          slow_off, fast_off, fifo_off;
    logic [DW-1:0] evt_bits;

    logic [DW-1:0] grp_set  [NGRP];
    logic [DW-1:0] grp_sts  [NGRP];
    logic [DW-1:0] grp_msk  [NGRP];
    logic          grp_pend [NGRP];
    logic          grp_sel  [NGRP];
    logic          grp_off  [NGRP];

    localparam logic [AW-1:0] STS_A [NGRP] = '{A_S_STS, A_F_STS};
    localparam logic [AW-1:0] MSK_A [NGRP] = '{A_S_MSK, A_F_MSK};
    localparam logic [AW-1:0] CLR_A [NGRP] = '{A_S_CLR, A_F_CLR};

    ir_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (reg_we_i && reg_addr_i == A_MODE),
        .wdata_i    (reg_wdata_i),
        .value_o    (mode_val),
        .mode_o     (mode),
        .slow_off_o (slow_off),
        .fast_off_o (fast_off),
        .fifo_off_o (fifo_off)
    );

    // group selection from the link mode; the reserved code routes nowhere
    always_comb begin
        evt_bits   = evt_to_bits(evt_i);
        grp_sel[0] = (mode == LM_SLOW);
        grp_sel[1] = (mode == LM_FAST) || (mode == LM_MED);
        grp_off[0] = slow_off;
        grp_off[1] = fast_off;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_set[g] = grp_sel[g] ? evt_bits : '0;

        ir_grp_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (grp_set[g]),
            .clr_we_i (reg_we_i && reg_addr_i == CLR_A[g]),
            .msk_we_i (reg_we_i && reg_addr_i == MSK_A[g]),
            .wdata_i  (reg_wdata_i),
            .status_o (grp_sts[g]),
            .mask_o   (grp_msk[g]),
            .pend_o   (grp_pend[g])
        );
    end

    // read multiplexer
    always_comb begin
        reg_rdata_o = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (reg_addr_i == STS_A[g]) reg_rdata_o = grp_sts[g];
            if (reg_addr_i == MSK_A[g]) reg_rdata_o = grp_msk[g];
        end
        if (reg_addr_i == A_MODE) reg_rdata_o = mode_val;
    end

    // interrupt combine
    always_comb begin
        irq_o = fifo_req_i && !fifo_off;
        for (int g = 0; g < NGRP; g++)
            irq_o = irq_o | (grp_pend[g] && !grp_off[g]);
    end

    // R2: the reserved mode code records nothing
    p_rsvd_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_RSVD && !reg_we_i) |=> ($stable(grp_sts[0]) && $stable(grp_sts[1])));

    // R2: slow mode never touches the medium/fast group
    p_slow_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_SLOW && !reg_we_i) |=> $stable(grp_sts[1]));

    // R9: an interrupt always has a source
    p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (fifo_req_i || reg_rdata_o == reg_rdata_o) && (fifo_req_i || grp_sts[0] != '0 || grp_sts[1] != '0));

    // R8: masked FIFO request with clean groups gives no interrupt
    p_fifo_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_off && grp_sts[0] == '0 && grp_sts[1] == '0) |-> !irq_o);

endmodule

// File: tb/ir_evt_irq_ctrl_tb_top.sv
// Bench: directed corner cases followed by seeded random traffic, checked
// against a register-level model written from the requirements.
module ir_evt_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [4:0]  evt = '0;
    logic        fifo_req = 1'b0;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;

    logic [15:0] m_mode;
    logic [15:0] m_st [2];
    logic [15:0] m_mk [2];

    ir_evt_irq_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we_i    (reg_we),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .evt_i       (evt),
        .fifo_req_i  (fifo_req),
        .irq_o       (irq)
    );

    always #4 clk = ~clk;

    function automatic logic [15:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_mode;
            3'd1: return m_st[0];
            3'd2: return m_mk[0];
            3'd4: return m_st[1];
            3'd5: return m_mk[1];
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic exp_irq(input logic f);
        logic r;
        r = f && !m_mode[8];
        if ((m_st[0] & ~m_mk[0]) != 16'h0 && !m_mode[0]) r = 1'b1;
        if ((m_st[1] & ~m_mk[1]) != 16'h0 && !m_mode[4]) r = 1'b1;
        return r;
    endfunction

    function automatic logic [15:0] ev_bits(input logic [4:0] e);
        return {e[4], 3'b0, e[3], 1'b0, e[2], e[1], e[0], 7'b0};
    endfunction

    task automatic model_reset();
        m_mode = 16'h0111;
        m_st[0] = 16'h0; m_st[1] = 16'h0;
        m_mk[0] = 16'h8B80; m_mk[1] = 16'h8B80;
    endtask

    // one cycle: drive, check pre-edge read and irq, then update the model
    task automatic cyc(input logic we, input logic [2:0] a, input logic [15:0] wd,
                       input logic [4:0] e, input logic f, input string tag);
        logic [15:0] clr;
        int g;
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = wd; evt = e; fifo_req = f;
        #1;
        n_vec++;
        if (reg_rdata !== exp_rd(a)) begin
            n_bad++;
            $display("FAIL %s read addr %0d: got %h expected %h", tag, a, reg_rdata, exp_rd(a));
        end
        n_vec++;
        if (irq !== exp_irq(f)) begin
            n_bad++;
            $display("FAIL %s irq: got %b expected %b", tag, irq, exp_irq(f));
        end
        @(posedge clk);
        g = (m_mode[15:14] == 2'b00) ? 0 : (m_mode[15] ? 1 : -1);
        for (int k = 0; k < 2; k++) begin
            clr = (we && a == ((k == 0) ? 3'd3 : 3'd6)) ? wd : 16'h0;
            m_st[k] = m_st[k] & ~clr;
            if (g == k) m_st[k] = m_st[k] | ev_bits(e);
            m_st[k] = m_st[k] & 16'h8B80;
            if (we && a == ((k == 0) ? 3'd2 : 3'd5)) m_mk[k] = wd & 16'h8B80;
        end
        if (we && a == 3'd0) m_mode = wd & 16'hC111;
    endtask

    task automatic rd_all(input string tag);
        for (int a = 0; a < 8; a++) cyc(1'b0, 3'(a), 16'h0, 5'h0, 1'b0, tag);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        rd_all("R1 reset");

        // R3: latch in slow mode, all unmasked
        cyc(1'b1, 3'd2, 16'h0000, 5'h0, 1'b0, "R6 unmask slow");
        cyc(1'b1, 3'd0, 16'h0110, 5'h0, 1'b0, "R7 enable slow");
        cyc(1'b0, 3'd1, 16'h0, 5'b10000, 1'b0, "R3 event");
        cyc(1'b0, 3'd1, 16'h0, 5'h0, 1'b0, "R3 held");
        cyc(1'b0, 3'd1, 16'h0, 5'b00101, 1'b0, "R3 more");
        rd_all("R11 readback");

        // R4: partial clear
        cyc(1'b1, 3'd3, 16'h0080, 5'h0, 1'b0, "R4 clear one");
        cyc(1'b0, 3'd1, 16'h0, 5'h0, 1'b0, "R4 check");

        // R5: event meets clear
        cyc(1'b1, 3'd3, 16'hFFFF, 5'b11111, 1'b0, "R5 collide");
        cyc(1'b0, 3'd1, 16'h0, 5'h0, 1'b0, "R5 check");

        // R6: per-bit mask keeps status but drops irq
        cyc(1'b1, 3'd2, 16'hFFFF, 5'h0, 1'b0, "R6 mask all");
        cyc(1'b0, 3'd1, 16'h0, 5'h0, 1'b0, "R6 check");

        // R10: write to status ignored
        cyc(1'b1, 3'd1, 16'h0000, 5'h0, 1'b0, "R10 write sts");
        cyc(1'b1, 3'd4, 16'hFFFF, 5'h0, 1'b0, "R10 write sts");
        rd_all("R10 check");

        // R2: routing per mode code
        cyc(1'b1, 3'd3, 16'hFFFF, 5'h0, 1'b0, "R4 wipe slow");
        cyc(1'b1, 3'd0, 16'h4000, 5'h0, 1'b0, "R2 mode 01");
        cyc(1'b0, 3'd1, 16'h0, 5'h1F, 1'b0, "R2 rsvd drop");
        rd_all("R2 rsvd");
        cyc(1'b1, 3'd0, 16'hC000, 5'h0, 1'b0, "R2 mode 11");
        cyc(1'b1, 3'd5, 16'h0000, 5'b01000, 1'b0, "R2 med");
        rd_all("R2 med");
        cyc(1'b1, 3'd0, 16'h8010, 5'h0, 1'b0, "R7 mode 10 fast off");
        cyc(1'b0, 3'd4, 16'h0, 5'b00010, 1'b0, "R7 fast masked");
        cyc(1'b0, 3'd4, 16'h0, 5'h0, 1'b0, "R7 fast masked");

        // R8: FIFO request
        cyc(1'b1, 3'd6, 16'hFFFF, 5'h0, 1'b1, "R8 fifo on");
        cyc(1'b0, 3'd0, 16'h0, 5'h0, 1'b1, "R8 fifo on");
        cyc(1'b1, 3'd0, 16'h0100, 5'h0, 1'b1, "R8 fifo on");
        cyc(1'b0, 3'd0, 16'h0, 5'h0, 1'b1, "R8 fifo masked");

        // R9: random traffic
        for (int i = 0; i < 3000; i++) begin
            logic        we;
            logic [2:0]  a;
            logic [15:0] wd;
            logic [4:0]  e;
            we = ($urandom % 3) == 0;
            a  = 3'($urandom % 8);
            wd = 16'($urandom);
            e  = (($urandom % 4) == 0) ? 5'($urandom) : 5'h0;
            cyc(we, a, wd, e, 1'($urandom % 2), "R9 random");
        end

        // R1: reset again mid-run
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        model_reset();
        rd_all("R1 re-reset");

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule